// File: doc/BRIEF.md
# Flow-Control Frame Generator

This block builds link-level flow-control frames for an Ethernet transmitter. It has two modes. In classic mode it sends a single-quanta pause frame. In priority mode it sends a frame with a per-class enable vector and one quanta field for each queue. Each request is latched until a frame can carry it. Requests from several queues are merged into one frame. An XOFF for a queue is held back while that queue's holdoff interval is still running.

The frame leaves the block one byte per accepted cycle, under a valid/ready handshake with start and end markers. Each frame is 60 bytes long. CRC is appended further down the transmit path, and arbitration against client traffic is also done outside the block. Quanta values and the station address are sampled when a frame is launched.

The sequencer has two states:
- `ST_IDLE`: no frame is being sent.
- `ST_SEND`: bytes are being emitted.

It has three transitions:
- launch: `ST_IDLE` to `ST_SEND`. This happens when at least one eligible request is pending in the current mode.
- advance: stays in `ST_SEND`. It occurs on each accepted byte that is not the last.
- finish: `ST_SEND` to `ST_IDLE`. It occurs when the 60th byte is accepted.

Because of this, at least one idle cycle separates any two frames.

Top module: `pfc_pause_gen`

## Requirements
- R1: Each frame is exactly 60 bytes. `out_sop` is high only on byte 0 and `out_eop` only on byte 59. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R2: Bytes 0-5 are 01 80 C2 00 00 01. Bytes 6-11 carry `station_addr`, most significant byte first. Bytes 12-13 are 88 08.
- R3: Request encoding:
  - For queue q, `queue_req` bit 2q requests XOFF and bit 2q+1 requests XON.
  - For `pause_req`, bit 0 requests XOFF and bit 1 requests XON.
  - A pair with both bits set makes no request.
- R4: With `pfc_mode`=0, bytes 14-15 are 00 01. Bytes 16-17 are `pause_quanta` for XOFF and 00 00 for XON. Bytes 18-59 are zero.
- R5: With `pfc_mode`=1, bytes 14-15 are 01 01 and byte 16 is 00. Byte 17 bit q is set when queue q is carried in the frame. Bytes 18+2q and 19+2q hold queue q's quanta, high byte first. The quanta comes from `queue_quanta` slice q for an XOFF, and is zero for an XON or an absent queue. All bytes from 34 to 59 are zero.
- R6: A request stays pending until a frame carries it. A later request for the same queue replaces an opposite earlier one. Requests from all queues that are pending and eligible at launch share one frame.
- R7: No frame starts while another is in progress. Requests made during a frame go into the next frame, which follows at least one idle cycle later.
- R8: After an XOFF for a channel is launched, a further XOFF for that channel waits until holdoff × `QUANTA_CYCLES` cycles have elapsed. XON requests and other queues are not delayed.
- R9: After reset `out_valid` is low and no request is pending.
- R10: Enable bits and quanta fields for queue indices at or above `NQ` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfc_mode | input | 1 | 1 = per-queue frames, 0 = classic pause |
| pause_req | input | 2 | Global request pair (bit 0 XOFF, bit 1 XON) |
| queue_req | input | 2*NQ | Per-queue request pairs |
| station_addr | input | 48 | Source address |
| pause_quanta | input | 16 | Classic XOFF quanta |
| pause_holdoff | input | 16 | Classic XOFF holdoff, in quanta |
| queue_quanta | input | 16*NQ | Per-queue XOFF quanta |
| queue_holdoff | input | 16*NQ | Per-queue XOFF holdoff, in quanta |
| out_ready | input | 1 | Downstream accepts a byte |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Byte valid |
| out_sop | output | 1 | First byte of frame |
| out_eop | output | 1 | Last byte of frame |

## Verification
The bench builds the block with `NQ`=4 and `QUANTA_CYCLES`=1. With `NQ`=4, merged frames can mix XON, XOFF and absent queues, and the upper enable bits and quanta fields can be seen to stay zero. With `QUANTA_CYCLES`=1 a holdoff of 100 expires in exactly 100 cycles. That short window can be crossed within a couple of frames, so the bench observes both a blocked XOFF and its later release.

// File: rtl/pfc_gen_pkg.sv
package pfc_gen_pkg;
    localparam int          FRAME_BYTES = 60;
    localparam int          MAX_QUEUES  = 8;
    localparam logic [47:0] CTRL_DA     = 48'h0180C2000001;
    localparam logic [15:0] CTRL_TYPE   = 16'h8808;
    localparam logic [15:0] OP_PAUSE    = 16'h0001;
    localparam logic [15:0] OP_PFC      = 16'h0101;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_t;
endpackage

// File: rtl/pfc_chan_track.sv
module pfc_chan_track #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          req_off,
    input  logic          req_on,
    input  logic          take,
    input  logic [QW-1:0] holdoff,
    output logic          want_off,
    output logic          want_on
);
    logic          pend_off;
    logic          pend_on;
    logic [QW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_off <= 1'b0;
            pend_on  <= 1'b0;
            hold_cnt <= '0;
        end else begin
            if (take && want_on)  pend_on  <= 1'b0;
            if (take && want_off) pend_off <= 1'b0;
            if (req_off && !req_on) begin
                pend_off <= 1'b1;
                pend_on  <= 1'b0;
            end else if (req_on && !req_off) begin
                pend_on  <= 1'b1;
                pend_off <= 1'b0;
            end
            if (take && want_off)
                hold_cnt <= holdoff;
            else if (tick && hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign want_on  = pend_on;
    assign want_off = pend_off && (hold_cnt == '0);

    // R8: a launched XOFF with nonzero holdoff makes the channel ineligible next cycle
    a_r8_holdoff_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (take && want_off && holdoff != '0) |=> !want_off);

    // R3: a request pair with both bits set leaves the pending state alone
    a_r3_both_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_off && req_on && !take) |=>
            (pend_off == $past(pend_off) && pend_on == $past(pend_on)));

    // R6: XON and XOFF are never pending together
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_off && pend_on));
endmodule

// File: rtl/pfc_frame_rom.sv
module pfc_frame_rom
    import pfc_gen_pkg::*;
#(
    parameter int NQ = 4
) (
    input  logic [5:0]      idx,
    input  logic            pfc_sel,
    input  logic [47:0]     sa,
    input  logic [NQ-1:0]   snap_en,
    input  logic [16*NQ-1:0] snap_q,
    input  logic [15:0]     snap_pq,
    output logic [7:0]      byte_o
);
    logic [7:0] en8;

    always_comb begin
        en8 = '0;
        en8[NQ-1:0] = snap_en;
    end

    always_comb begin
        byte_o = 8'h00;
        for (int i = 0; i < 6; i++) begin
            if (idx == 6'(i))     byte_o = CTRL_DA[8*(5-i) +: 8];
            if (idx == 6'(i + 6)) byte_o = sa[8*(5-i) +: 8];
        end
        if (idx == 6'd12) byte_o = CTRL_TYPE[15:8];
        if (idx == 6'd13) byte_o = CTRL_TYPE[7:0];
        if (idx == 6'd14) byte_o = pfc_sel ? OP_PFC[15:8] : OP_PAUSE[15:8];
        if (idx == 6'd15) byte_o = pfc_sel ? OP_PFC[7:0]  : OP_PAUSE[7:0];
        if (pfc_sel) begin
            if (idx == 6'd17) byte_o = en8;
            for (int q = 0; q < NQ; q++) begin
                if (idx == 6'(18 + 2*q)) byte_o = snap_q[16*q + 8 +: 8];
                if (idx == 6'(19 + 2*q)) byte_o = snap_q[16*q +: 8];
            end
        end else begin
            if (idx == 6'd16) byte_o = snap_pq[15:8];
            if (idx == 6'd17) byte_o = snap_pq[7:0];
        end
    end
endmodule

// File: rtl/pfc_pause_gen.sv
module pfc_pause_gen
    import pfc_gen_pkg::*;
#(
    parameter int NQ            = 4,
    parameter int QUANTA_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pfc_mode,
    input  logic [1:0]       pause_req,
    input  logic [2*NQ-1:0]  queue_req,
    input  logic [47:0]      station_addr,
    input  logic [15:0]      pause_quanta,
    input  logic [15:0]      pause_holdoff,
    input  logic [16*NQ-1:0] queue_quanta,
    input  logic [16*NQ-1:0] queue_holdoff,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop
);
    localparam logic [5:0] LAST_IDX = 6'(FRAME_BYTES - 1);

    tx_state_t        state;
    logic [5:0]       idx;
    logic             tick;
    logic             launch;
    logic [NQ-1:0]    q_off, q_on;
    logic             g_off, g_on;
    logic             snap_pfc;
    logic [NQ-1:0]    snap_en;
    logic [16*NQ-1:0] snap_q;
    logic [15:0]      snap_pq;
    logic [47:0]      snap_sa;

    generate
        if (QUANTA_CYCLES == 1) begin : g_tick_every
            assign tick = 1'b1;
        end else begin : g_tick_div
            localparam int PW = $clog2(QUANTA_CYCLES);
            localparam logic [PW-1:0] PLAST = PW'(QUANTA_CYCLES - 1);
            logic [PW-1:0] pre;
            always_ff @(posedge clk) begin
                if (!rst_n)            pre <= '0;
                else if (pre == PLAST) pre <= '0;
                else                   pre <= pre + 1'b1;
            end
            assign tick = (pre == PLAST);
        end
    endgenerate

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_queue
            pfc_chan_track #(.QW(16)) u_trk (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick),
                .req_off  (queue_req[2*q]),
                .req_on   (queue_req[2*q+1]),
                .take     (launch && pfc_mode),
                .holdoff  (queue_holdoff[16*q +: 16]),
                .want_off (q_off[q]),
                .want_on  (q_on[q])
            );
        end
    endgenerate

    pfc_chan_track #(.QW(16)) u_global (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .req_off  (pause_req[0]),
        .req_on   (pause_req[1]),
        .take     (launch && !pfc_mode),
        .holdoff  (pause_holdoff),
        .want_off (g_off),
        .want_on  (g_on)
    );

    assign launch = (state == ST_IDLE) &&
                    (pfc_mode ? |(q_off | q_on) : (g_off | g_on));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (launch) state <= ST_SEND;
                end
                ST_SEND: begin
                    if (out_ready) begin
                        if (idx == LAST_IDX) begin
                            state <= ST_IDLE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // frame snapshot taken at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_pfc <= 1'b0;
            snap_en  <= '0;
            snap_q   <= '0;
            snap_pq  <= '0;
            snap_sa  <= '0;
        end else if (launch) begin
            snap_pfc <= pfc_mode;
            snap_sa  <= station_addr;
            snap_pq  <= g_off ? pause_quanta : 16'h0000;
            for (int q = 0; q < NQ; q++) begin
                snap_en[q]       <= q_off[q] | q_on[q];
                snap_q[16*q +: 16] <= q_off[q] ? queue_quanta[16*q +: 16] : 16'h0000;
            end
        end
    end

    pfc_frame_rom #(.NQ(NQ)) u_rom (
        .idx     (idx),
        .pfc_sel (snap_pfc),
        .sa      (snap_sa),
        .snap_en (snap_en),
        .snap_q  (snap_q),
        .snap_pq (snap_pq),
        .byte_o  (out_data)
    );

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SEND: begin
                out_valid = 1'b1;
                out_sop   = (idx == '0);
                out_eop   = (idx == LAST_IDX);
            end
            default: ;
        endcase
    end

    // R1: stalled byte stays put
    a_r1_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R1: a frame always opens with the start marker
    a_r1_sop_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_sop);

    // R7: accepted end byte is followed by an idle cycle
    a_r7_gap_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eop && out_ready) |=> !out_valid);

    // R2: first byte is the reserved multicast prefix
    a_r2_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> (out_data == 8'h01));
endmodule

// File: tb/tb_pfc_pause_gen.sv
module tb_pfc_pause_gen;
    localparam int NQ = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             pfc_mode;
    logic [1:0]       pause_req;
    logic [2*NQ-1:0]  queue_req;
    logic [47:0]      station_addr;
    logic [15:0]      pause_quanta, pause_holdoff;
    logic [16*NQ-1:0] queue_quanta, queue_holdoff;
    logic             out_ready;
    logic [7:0]       out_data;
    logic             out_valid, out_sop, out_eop;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] fr [0:59];
    logic [7:0] ex [0:59];

    always #10 clk = ~clk;

    pfc_pause_gen #(.NQ(NQ), .QUANTA_CYCLES(1)) dut (
        .clk(clk), .rst_n(rst_n), .pfc_mode(pfc_mode), .pause_req(pause_req),
        .queue_req(queue_req), .station_addr(station_addr),
        .pause_quanta(pause_quanta), .pause_holdoff(pause_holdoff),
        .queue_quanta(queue_quanta), .queue_holdoff(queue_holdoff),
        .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_q(input logic [2*NQ-1:0] v);
        @(negedge clk); queue_req = v;
        @(negedge clk); queue_req = '0;
    endtask

    task automatic pulse_p(input logic [1:0] v);
        @(negedge clk); pause_req = v;
        @(negedge clk); pause_req = '0;
    endtask

    task automatic mk_exp(input bit pfc, input logic [7:0] en,
                          input logic [15:0] q0, input logic [15:0] q1,
                          input logic [15:0] q2, input logic [15:0] q3,
                          input logic [15:0] pq);
        logic [15:0] qa [0:3];
        qa[0] = q0; qa[1] = q1; qa[2] = q2; qa[3] = q3;
        for (int i = 0; i < 60; i++) ex[i] = 8'h00;
        ex[0] = 8'h01; ex[1] = 8'h80; ex[2] = 8'hC2; ex[3] = 8'h00; ex[4] = 8'h00; ex[5] = 8'h01;
        for (int i = 0; i < 6; i++) ex[6+i] = station_addr[8*(5-i) +: 8];
        ex[12] = 8'h88; ex[13] = 8'h08;
        ex[14] = pfc ? 8'h01 : 8'h00; ex[15] = 8'h01;
        if (pfc) begin
            ex[17] = en;
            for (int q = 0; q < 4; q++) begin
                ex[18+2*q] = qa[q][15:8];
                ex[19+2*q] = qa[q][7:0];
            end
        end else begin
            ex[16] = pq[15:8]; ex[17] = pq[7:0];
        end
    endtask

    task automatic cmp_frame(input string tag);
        for (int i = 0; i < 60; i++) begin
            string where;
            if (i < 14)      where = "R2";
            else if (i < 18) where = tag;
            else             where = {tag, " R10"};
            chk($sformatf("%s byte %0d", where, i), {24'h0, fr[i]}, {24'h0, ex[i]});
        end
    endtask

    task automatic collect(input bit stall);
        int n = 0;
        int g = 0;
        while (n < 60 && g < 2000) begin
            @(negedge clk);
            g++;
            out_ready = stall ? (g % 3 != 0) : 1'b1;
            if (out_valid && out_ready) begin
                fr[n] = out_data;
                chk($sformatf("R1 sop at byte %0d", n), {31'h0, out_sop}, {31'h0, (n == 0)});
                chk($sformatf("R1 eop at byte %0d", n), {31'h0, out_eop}, {31'h0, (n == 59)});
                n++;
            end
        end
        chk("R1 frame length", n, 60);
        @(negedge clk);
        out_ready = 1'b0;
        chk("R7 idle cycle after frame", {31'h0, out_valid}, 32'h0);
    endtask

    task automatic quiet(input int cycles, input string tag);
        int hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (out_valid) hits++;
        end
        chk(tag, hits, 0);
    endtask

    task automatic t_reset;
        chk("R9 out_valid after reset", {31'h0, out_valid}, 32'h0);
        quiet(10, "R9 nothing pending after reset");
    endtask

    task automatic t_classic_xoff;
        pfc_mode = 1'b0;
        pulse_p(2'b01);
        collect(1'b0);
        mk_exp(1'b0, 8'h00, 16'h0, 16'h0, 16'h0, 16'h0, 16'h1234);
        cmp_frame("R4 xoff");
    endtask

    task automatic t_classic_xon;
        pulse_p(2'b10);
        collect(1'b1);
        mk_exp(1'b0, 8'h00, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0000);
        cmp_frame("R4 xon");
    endtask

    task automatic t_both_set;
        pulse_p(2'b11);
        quiet(80, "R3 both bits classic ignored");
        pfc_mode = 1'b1;
        pulse_q(8'b0000_1100);
        quiet(80, "R3 both bits queue1 ignored");
    endtask

    task automatic t_pfc_merge;
        pfc_mode = 1'b1;
        // q0 XOFF (bit0), q2 XON (bit5), q3 XOFF (bit6)
        pulse_q(8'b0110_0001);
        collect(1'b0);
        mk_exp(1'b1, 8'h0D, 16'h1100, 16'h0, 16'h0, 16'h1103, 16'h0);
        cmp_frame("R5 merge");
    endtask

    task automatic t_overwrite;
        pulse_q(8'b0000_1000);              // q1 XON launches frame
        pulse_q(8'b0001_0000);              // q2 XOFF while frame pending
        pulse_q(8'b0010_0000);              // q2 XON replaces it (R6)
        collect(1'b1);
        mk_exp(1'b1, 8'h02, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
        cmp_frame("R7 first");
        collect(1'b0);
        mk_exp(1'b1, 8'h04, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
        cmp_frame("R6 replaced");
    endtask

    task automatic t_holdoff;
        queue_holdoff[15:0] = 16'd100;
        pulse_q(8'b0000_0001);
        collect(1'b0);
        mk_exp(1'b1, 8'h01, 16'h1100, 16'h0, 16'h0, 16'h0, 16'h0);
        cmp_frame("R8 first xoff");
        pulse_q(8'b0000_0001);
        quiet(20, "R8 xoff held during holdoff");
        pulse_q(8'b0000_1000);
        collect(1'b0);
        mk_exp(1'b1, 8'h02, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
        cmp_frame("R8 xon not delayed");
        collect(1'b0);
        mk_exp(1'b1, 8'h01, 16'h1100, 16'h0, 16'h0, 16'h0, 16'h0);
        cmp_frame("R8 xoff released");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        pfc_mode = 1'b0;
        pause_req = '0;
        queue_req = '0;
        station_addr = 48'hA1B2C3D4E5F6;
        pause_quanta = 16'h1234;
        pause_holdoff = 16'h0;
        queue_quanta = {16'h1103, 16'h1102, 16'h1101, 16'h1100};
        queue_holdoff = '0;
        out_ready = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_classic_xoff();
        t_classic_xon();
        t_both_set();
        t_pfc_merge();
        t_overwrite();
        t_holdoff();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule